// File: doc/BRIEF.md
# Reset Boot Mode Sequencer

This block decides how a processor core comes up once reset is removed. While reset is held it captures three straps: a two-bit start-up mode, a host-path select and a byte-order select. When reset drops it follows one of three paths. It can keep the core stalled until an external host writes a completion bit. It can copy a fixed 1 KB image from a byte-wide ROM into word-wide internal memory and then free the core. It can also free the core at once.

For the copy, the block fetches ROM bytes one at a time over a request/valid handshake. The ROM may insert any number of wait cycles. The block packs each group of four bytes into a 32-bit word in the selected byte order and writes the word to consecutive word addresses from zero. The completion bit serves as the host's release signal. Once the core is running, the same bit acts as a one-shot interrupt source that the core must clear before it can fire again.

Top module: `boot_seq_top`

## Requirements
- R1: While `rst` is high (sampled at a clock edge), `core_stall` is 1, `phase` is 0 (reset), `rom_req`, `mem_we` and `core_irq` are 0, and `start_addr` is 0.
- R2: The straps are captured while `rst` is high. For `mode_sel` 2'b00 or 2'b11 (no boot), the first clock edge after `rst` falls sets `core_stall` to 0 and `phase` to 3 (running). No ROM request and no memory write follow.
- R3: For `mode_sel` 2'b01 (host boot), `phase` is 1 and `core_stall` stays 1 until a host write with `host_bit` = 1 is accepted. The clock edge that accepts the write sets `core_stall` to 0 and `phase` to 3. A host write with `host_bit` = 0 has no effect.
- R4: `host_port` equals the `port_sel` value captured during reset (0 = first host path, 1 = second) and holds that value until the next reset.
- R5: In ROM boot (`mode_sel` 2'b10), a host write of the completion bit during the copy leaves `core_stall` at 1 and `phase` at 2 (copying).
- R6: An accepted completion write produces no `core_irq` while the core is stalled. After release, the bit stays set until a `core_clr` pulse. Host writes made while it is set raise no `core_irq`. After it is cleared, a host write with `host_bit` = 1 raises `core_irq` for exactly one cycle.
- R7: In ROM boot, `rom_addr` steps through byte addresses 0 to 1023 in ascending order, one byte per `rom_valid` cycle while `rom_req` is 1. `rom_addr` holds steady while the request waits, whatever the wait count.
- R8: With `big_endian` = 0, the byte at ROM address 4w+k goes to bits [8k+7:8k] of word w. With `big_endian` = 1, it goes to bits [8(3-k)+7:8(3-k)].
- R9: The copy issues exactly 256 one-cycle `mem_we` pulses at word addresses 0 to 255 in ascending order. `word_cnt` counts the writes and ends at 256.
- R10: After the last word write, `core_stall` falls and `phase` becomes 3. `start_addr` is 0 in every mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 2 | Start-up mode strap: 01 host, 10 ROM copy, 00/11 none |
| port_sel | input | 1 | Host path select strap |
| big_endian | input | 1 | Byte order strap for ROM packing |
| host_wr | input | 1 | Host control register write strobe |
| host_bit | input | 1 | Completion bit value written by the host |
| core_clr | input | 1 | Core clears the completion bit |
| rom_rdata | input | 8 | ROM read byte |
| rom_valid | input | 1 | ROM byte valid |
| rom_req | output | 1 | ROM read request |
| rom_addr | output | 10 | ROM byte address |
| mem_we | output | 1 | Internal memory word write strobe |
| mem_addr | output | 8 | Internal memory word address |
| mem_wdata | output | 32 | Internal memory write word |
| core_stall | output | 1 | Core held stalled |
| start_addr | output | 32 | Core start address |
| host_port | output | 1 | Captured host path select |
| phase | output | 2 | 0 reset, 1 waiting for host, 2 copying, 3 running |
| core_irq | output | 1 | One-cycle completion interrupt to the running core |
| word_cnt | output | 9 | Number of words written by the copy |

## Verification
The hardest case to reach is a completion write that lands in the middle of a ROM copy, while bytes are still moving under random wait states. The bench produces it by issuing a host write a fixed number of cycles into a ROM boot and then checking that the stall and the copying phase both hold. Random rounds then mix modes, byte orders, wait counts and host write times. Each finished image is compared word by word against a bench-computed packing of a known byte pattern.

// File: rtl/boot_seq_pkg.sv
package boot_seq_pkg;
  typedef enum logic [1:0] {
    PH_RESET = 2'd0,
    PH_HOST  = 2'd1,
    PH_COPY  = 2'd2,
    PH_RUN   = 2'd3
  } phase_t;

  localparam logic [1:0] MODE_HOST = 2'b01;
  localparam logic [1:0] MODE_ROM  = 2'b10;
endpackage

// File: rtl/boot_host_flag.sv
module boot_host_flag (
  input  logic clk,
  input  logic rst,
  input  logic host_wr,
  input  logic host_bit,
  input  logic core_clr,
  input  logic running,
  output logic flag,
  output logic accept,
  output logic core_irq
);
  // A new completion event is taken only while the bit is clear
  assign accept = host_wr && host_bit && !flag;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag     <= 1'b0;
      core_irq <= 1'b0;
    end else begin
      core_irq <= accept && running;
      if (accept)
        flag <= 1'b1;
      else if (core_clr && running)
        flag <= 1'b0;
    end
  end

  // R6: interrupt never reaches a stalled core and is a single pulse
  assert_irq_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    core_irq |=> !core_irq);
  assert_irq_needs_flag_R6: assert property (@(posedge clk) disable iff (rst)
    core_irq |-> flag);
endmodule

// File: rtl/boot_rom_copier.sv
module boot_rom_copier #(
  parameter int IMG_BYTES = 1024,
  localparam int AW    = $clog2(IMG_BYTES),
  localparam int WORDS = IMG_BYTES / 4,
  localparam int WAW   = $clog2(WORDS),
  localparam int CW    = WAW + 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic           big_endian,
  input  logic [7:0]     rom_rdata,
  input  logic           rom_valid,
  output logic           rom_req,
  output logic [AW-1:0]  rom_addr,
  output logic           mem_we,
  output logic [WAW-1:0] mem_addr,
  output logic [31:0]    mem_wdata,
  output logic [CW-1:0]  word_cnt,
  output logic           done
);
  logic [31:0] pack_q, pack_nxt;
  logic [1:0]  lane;

  assign lane = big_endian ? 2'd3 - rom_addr[1:0] : rom_addr[1:0];

  always_comb begin
    pack_nxt = pack_q;
    for (int k = 0; k < 4; k++)
      if (lane == 2'(k)) pack_nxt[8*k +: 8] = rom_rdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rom_req   <= 1'b0;
      rom_addr  <= '0;
      pack_q    <= '0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      word_cnt  <= '0;
      done      <= 1'b0;
    end else begin
      mem_we <= 1'b0;
      done   <= 1'b0;
      if (start) begin
        rom_req  <= 1'b1;
        rom_addr <= '0;
        word_cnt <= '0;
      end else if (rom_req && rom_valid) begin
        pack_q <= pack_nxt;
        if (rom_addr[1:0] == 2'd3) begin
          mem_we    <= 1'b1;
          mem_addr  <= rom_addr[AW-1:2];
          mem_wdata <= pack_nxt;
        end
        if (rom_addr == AW'(IMG_BYTES - 1))
          rom_req <= 1'b0;
        else
          rom_addr <= rom_addr + 1'b1;
      end
      if (mem_we) begin
        word_cnt <= word_cnt + 1'b1;
        if (word_cnt == CW'(WORDS - 1)) done <= 1'b1;
      end
    end
  end

  // R7: address held while the ROM has not answered
  assert_addr_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (rom_req && !rom_valid && !start) |=> $stable(rom_addr));
  // R9: word writes are isolated pulses and the count never overruns
  assert_we_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> !mem_we);
  assert_cnt_bound_R9: assert property (@(posedge clk) disable iff (rst)
    word_cnt <= CW'(WORDS));
endmodule

// File: rtl/boot_seq_top.sv
module boot_seq_top
  import boot_seq_pkg::*;
#(
  parameter int IMG_BYTES = 1024,
  parameter int ADDR_W    = 32,
  localparam int AW    = $clog2(IMG_BYTES),
  localparam int WAW   = $clog2(IMG_BYTES / 4),
  localparam int CW    = WAW + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        mode_sel,
  input  logic              port_sel,
  input  logic              big_endian,
  input  logic              host_wr,
  input  logic              host_bit,
  input  logic              core_clr,
  input  logic [7:0]        rom_rdata,
  input  logic              rom_valid,
  output logic              rom_req,
  output logic [AW-1:0]     rom_addr,
  output logic              mem_we,
  output logic [WAW-1:0]    mem_addr,
  output logic [31:0]       mem_wdata,
  output logic              core_stall,
  output logic [ADDR_W-1:0] start_addr,
  output logic              host_port,
  output logic [1:0]        phase,
  output logic              core_irq,
  output logic [CW-1:0]     word_cnt
);
  phase_t     ph_q;
  logic [1:0] mode_q;
  logic       endian_q, copy_start, copy_done, accept, flag;

  assign phase = ph_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q       <= PH_RESET;
      core_stall <= 1'b1;
      mode_q     <= mode_sel;
      host_port  <= port_sel;
      endian_q   <= big_endian;
      copy_start <= 1'b0;
      start_addr <= '0;
    end else begin
      copy_start <= 1'b0;
      unique case (ph_q)
        PH_RESET: begin
          if (mode_q == MODE_HOST) begin
            ph_q <= PH_HOST;
          end else if (mode_q == MODE_ROM) begin
            ph_q       <= PH_COPY;
            copy_start <= 1'b1;
          end else begin
            ph_q       <= PH_RUN;
            core_stall <= 1'b0;
          end
        end
        PH_HOST: if (accept) begin
          ph_q       <= PH_RUN;
          core_stall <= 1'b0;
        end
        PH_COPY: if (copy_done) begin
          ph_q       <= PH_RUN;
          core_stall <= 1'b0;
        end
        PH_RUN: ;
        default: ph_q <= PH_RESET;
      endcase
    end
  end

  boot_host_flag u_flag (
    .clk(clk), .rst(rst), .host_wr(host_wr), .host_bit(host_bit),
    .core_clr(core_clr), .running(!core_stall), .flag(flag),
    .accept(accept), .core_irq(core_irq)
  );

  boot_rom_copier #(.IMG_BYTES(IMG_BYTES)) u_copy (
    .clk(clk), .rst(rst), .start(copy_start), .big_endian(endian_q),
    .rom_rdata(rom_rdata), .rom_valid(rom_valid), .rom_req(rom_req),
    .rom_addr(rom_addr), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .word_cnt(word_cnt), .done(copy_done)
  );

  // R5: a copy leaves only toward running, never through the host path
  assert_copy_exit_R5: assert property (@(posedge clk) disable iff (rst)
    (ph_q == PH_COPY) |=> (ph_q == PH_COPY || ph_q == PH_RUN));
  // R10: the core is stalled whenever a copy is under way
  assert_stall_in_copy_R10: assert property (@(posedge clk) disable iff (rst)
    (ph_q == PH_COPY || rom_req || mem_we) |-> core_stall);
  // R4: captured host path does not move after reset
  assert_port_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (ph_q != PH_RESET) |-> $stable(host_port));
  // R6: no interrupt while stalled
  assert_no_irq_stalled_R6: assert property (@(posedge clk) disable iff (rst)
    core_irq |-> !core_stall);
endmodule

// File: tb/boot_seq_top_bench.sv
module boot_seq_top_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] mode_sel = 2'b00;
  logic port_sel = 1'b0, big_endian = 1'b0;
  logic host_wr = 1'b0, host_bit = 1'b0, core_clr = 1'b0;
  logic [7:0] rom_rdata = 8'h00;
  logic rom_valid = 1'b0;
  logic rom_req, mem_we, core_stall, host_port, core_irq;
  logic [9:0] rom_addr;
  logic [7:0] mem_addr;
  logic [31:0] mem_wdata, start_addr;
  logic [1:0] phase;
  logic [8:0] word_cnt;

  int n_chk = 0, n_bad = 0, cyc = 0;
  int wait_n = 0, wcnt = 0, exp_byte = 0, exp_word = 0, salt = 0;
  logic cur_be = 1'b0;

  always #10 clk = ~clk;

  boot_seq_top u_boot_seq_top (
    .clk(clk), .rst(rst), .mode_sel(mode_sel), .port_sel(port_sel),
    .big_endian(big_endian), .host_wr(host_wr), .host_bit(host_bit),
    .core_clr(core_clr), .rom_rdata(rom_rdata), .rom_valid(rom_valid),
    .rom_req(rom_req), .rom_addr(rom_addr), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .core_stall(core_stall),
    .start_addr(start_addr), .host_port(host_port), .phase(phase),
    .core_irq(core_irq), .word_cnt(word_cnt)
  );

  function automatic logic [7:0] rom_byte(int a, int s);
    return 8'((a * 37 + s) ^ (a >> 3));
  endfunction

  function automatic logic [31:0] exp_pack(int w, int s, logic be);
    logic [31:0] v = '0;
    for (int k = 0; k < 4; k++) begin
      int ln = be ? 3 - k : k;
      v[8*ln +: 8] = rom_byte(4*w + k, s);
    end
    return v;
  endfunction

  task automatic chk(bit ok, string tag, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      finish_run();
    end
  end

  // ROM model and monitors, away from the active edge
  always @(negedge clk) begin
    if (rom_req && !rst) begin
      if (wcnt >= wait_n) begin
        rom_valid = 1'b1;
        rom_rdata = rom_byte(int'(rom_addr), salt);
        chk(int'(rom_addr) == exp_byte, "R7 rom order", rom_addr, exp_byte);
        exp_byte++;
        wcnt = 0;
      end else begin
        rom_valid = 1'b0;
        wcnt++;
      end
    end else begin
      rom_valid = 1'b0;
    end
    if (mem_we && !rst) begin
      chk(int'(mem_addr) == exp_word, "R9 word addr", mem_addr, exp_word);
      chk(mem_wdata == exp_pack(int'(mem_addr), salt, cur_be), "R8 packing",
          mem_wdata, exp_pack(int'(mem_addr), salt, cur_be));
      exp_word++;
    end
  end

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(logic [1:0] m, logic p, logic be, int w);
    tick();
    rst = 1'b1; mode_sel = m; port_sel = p; big_endian = be;
    wait_n = w; salt = int'($urandom_range(0, 255));
    cur_be = be;
    tick(3);
    chk(core_stall == 1'b1 && phase == 2'd0, "R1 reset stall/phase",
        {core_stall, phase}, 3'b100);
    chk(!rom_req && !mem_we && !core_irq && start_addr == 0, "R1 reset quiet",
        {rom_req, mem_we, core_irq}, 0);
    exp_byte = 0; exp_word = 0; wcnt = 0;
    rst = 1'b0;
    mode_sel = ~m; port_sel = ~p; big_endian = ~be;  // straps move after reset
    tick();
  endtask

  task automatic host_write(logic b);
    host_wr = 1'b1; host_bit = b; tick();
    host_wr = 1'b0; host_bit = 1'b0;
  endtask

  task automatic run_none(logic [1:0] m);
    do_reset(m, 1'b0, 1'b0, 0);
    chk(core_stall == 0 && phase == 2'd3, "R2 no boot runs", {core_stall, phase}, 3);
    tick(20);
    chk(exp_byte == 0 && exp_word == 0, "R2 no copy activity", exp_byte + exp_word, 0);
    chk(start_addr == 0, "R10 start address", start_addr, 0);
  endtask

  task automatic run_host(logic p, int hold);
    do_reset(2'b01, p, 1'b0, 0);
    chk(host_port == p, "R4 host port", host_port, p);
    tick(hold);
    chk(core_stall == 1 && phase == 2'd1, "R3 host wait", {core_stall, phase}, 3'b101);
    host_write(1'b0);
    chk(core_stall == 1, "R3 zero write ignored", core_stall, 1);
    host_write(1'b1);
    chk(core_stall == 0 && phase == 2'd3, "R3 host release", {core_stall, phase}, 3);
    chk(core_irq == 0, "R6 no irq at release", core_irq, 0);
    chk(host_port == p && start_addr == 0, "R4 port held", host_port, p);
    tick(2);
    host_write(1'b1);
    chk(core_irq == 0, "R6 set bit blocks event", core_irq, 0);
    core_clr = 1'b1; tick(); core_clr = 1'b0;
    host_write(1'b1);
    chk(core_irq == 1, "R6 irq after clear", core_irq, 1);
    tick();
    chk(core_irq == 0, "R6 irq one cycle", core_irq, 0);
  endtask

  task automatic run_rom(logic be, int w, int poke);
    int lim = 0;
    do_reset(2'b10, 1'b0, be, w);
    chk(phase == 2'd2 && core_stall == 1, "R10 copy stalled", {core_stall, phase}, 3'b110);
    tick(poke);
    host_write(1'b1);
    chk(core_stall == 1 && phase == 2'd2, "R5 host bit ignored in copy",
        {core_stall, phase}, 3'b110);
    while (phase != 2'd3 && lim < 30000) begin tick(); lim++; end
    chk(exp_word == 256 && word_cnt == 9'd256, "R9 word total", word_cnt, 256);
    chk(exp_byte == 1024, "R7 byte total", exp_byte, 1024);
    chk(core_stall == 0 && start_addr == 0, "R10 release after copy",
        core_stall, 0);
    tick(3);
    chk(!rom_req && exp_word == 256, "R9 no extra writes", exp_word, 256);
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    tick(2);
    run_none(2'b00);
    run_none(2'b11);
    run_host(1'b0, 5);
    run_host(1'b1, 40);
    run_rom(1'b0, 0, 10);
    run_rom(1'b1, 2, 37);
    for (int i = 0; i < 6; i++) begin
      int m = int'($urandom_range(0, 3));
      if (m == 1) run_host(1'($urandom_range(0, 1)), int'($urandom_range(1, 30)));
      else if (m == 2) run_rom(1'($urandom_range(0, 1)), int'($urandom_range(0, 4)),
                               int'($urandom_range(1, 200)));
      else run_none(2'(m));
    end
    finish_run();
  end
endmodule